// File: doc/BRIEF.md
# Register-Transfer Update Strobe Generator

This block produces the strobe that tells a programmable core to copy its staged settings into its active registers. There are two ways to produce it. In self-timed mode a 32-bit down-counter, stepped once every two system clocks, issues a transfer at a fixed programmed spacing. It also drives an 8-clock-wide marker pulse onto a shared bidirectional pin so that external logic can line up its own writes with the transfers. In pin-driven mode the pin is released and becomes an input. Its low-to-high transitions are brought into the system clock domain and each one yields exactly one transfer, so a register copy never starts on a half-settled value.

The mode select comes from a configuration bit. It is captured in a local flop that comes out of reset in self-timed mode, so the pin is driven from the moment reset is applied. The interval value N is read directly from the configuration register.

Top module: `xfer_strobe_gen`

## Requirements
- R1: In pin-driven mode each low-to-high transition of `pin_in` yields exactly one transfer strobe. This holds however long the pin stays high, and also for a high level lasting only one clock.
- R2: The captured mode resets to self-timed. While reset is applied, `pin_oe` is 1 whatever the level of `int_mode`.
- R3: In pin-driven mode, `xfer_stb` is high in the cycle after the third rising clock edge that follows the `pin_in` transition. This latency comes from two synchronizing flops and one output register.
- R4: In self-timed mode the counter changes value at most once every two clocks. When it reaches zero it reloads N and keeps counting.
- R5: In self-timed mode, strobes are spaced (N+1)×2 clocks apart, where N lies between 1 and 2^32−1. The first strobe comes two clocks after the captured mode turns self-timed, or two clocks after reset is released.
- R6: For N of 5 or more, `pin_out` is high for exactly 8 clocks. The high time starts in the cycle of each self-timed strobe, and the pin is low in the ninth cycle.
- R7: For N below 5, `pin_out` stays high in self-timed mode and strobes still arrive at the R5 spacing.
- R8: `int_mode` is captured one clock before it takes effect. `pin_oe` equals the captured mode (1 = self-timed). In pin-driven mode `pin_out` is 0, and the self-timed counter is cleared so that it restarts from zero on re-entry.
- R9: In self-timed mode, activity on `pin_in` produces no strobe.
- R10: `xfer_stb` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| interval_n | input | 32 | Programmed interval N for self-timed mode |
| int_mode | input | 1 | Mode select: 1 self-timed, 0 pin-driven |
| pin_in | input | 1 | Level seen on the shared pin |
| pin_out | output | 1 | Value driven onto the shared pin |
| pin_oe | output | 1 | Drive enable for the shared pin (1 = block drives it) |
| xfer_stb | output | 1 | One-cycle transfer strobe to the staged registers |

## Verification
A half-rate phase that drifts, or a reload that is off by one, moves every later strobe. This shows at the ports as a strobe in the wrong cycle at the first or second interval after entering self-timed mode. A pulse stretcher that loads the wrong value shows up eight or nine cycles after a strobe, as `pin_out` staying high or falling early. A synchronizer with a wrong stage count, or with broken edge detection, shows at the first external transition: the strobe comes early or late, or a long high level makes more than one strobe.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int XFER_CNT_W       = 32;
  localparam int XFER_HOLD_CYCLES = 8;
  localparam int XFER_SMALL_N     = 5;
  localparam int XFER_SYNC_STAGES = 2;

  typedef enum logic {
    MODE_PIN  = 1'b0,
    MODE_SELF = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/half_rate_counter.sv
module half_rate_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  output logic             fire
);
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire    = en && ph_q && at_zero;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = 1'b0;
      cnt_d = '0;
    end else begin
      ph_d = ~ph_q;
      if (ph_q) begin
        cnt_d = at_zero ? reload_val : cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  AST_HALF_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ph_q) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig,
  output logic active
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [HOLD_W-1:0] hcnt_q, hcnt_d;

  assign active = (hcnt_q != '0);

  always_comb begin
    hcnt_d = hcnt_q;
    if (!en) begin
      hcnt_d = '0;
    end else if (trig) begin
      hcnt_d = HOLD_W'(HOLD_CYCLES);
    end else if (active) begin
      hcnt_d = hcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end

  AST_TRIG_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trig) |=> active); // R6
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_d[g] = async_in;
      end else begin : g_next
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  assign rise = sync_q[STAGES-1] & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  AST_RISE_FROM_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(sync_q[STAGES-2])); // R1
endmodule

// File: rtl/xfer_strobe_gen.sv
module xfer_strobe_gen
  import xfer_pkg::*;
#(
  parameter int CNT_W       = XFER_CNT_W,
  parameter int HOLD_CYCLES = XFER_HOLD_CYCLES,
  parameter int SMALL_N     = XFER_SMALL_N,
  parameter int SYNC_STAGES = XFER_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval_n,
  input  logic             int_mode,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             xfer_stb
);
  upd_mode_e mode_q, mode_d;
  logic      stb_q, stb_d;
  logic      self_en, int_fire, ext_rise, hold_active, small_n;

  assign self_en = (mode_q == MODE_SELF);
  assign small_n = (interval_n < CNT_W'(SMALL_N));

  half_rate_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .en(self_en),
    .reload_val(interval_n), .fire(int_fire)
  );

  pulse_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) i_stretch (
    .clk(clk), .rst_n(rst_n), .en(self_en),
    .trig(int_fire), .active(hold_active)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .rise(ext_rise)
  );

  always_comb begin
    mode_d = upd_mode_e'(int_mode);
    stb_d  = self_en ? int_fire : ext_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SELF;
      stb_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stb_q  <= stb_d;
    end
  end

  assign pin_oe   = self_en;
  assign pin_out  = self_en & (hold_active | small_n);
  assign xfer_stb = stb_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |=> !xfer_stb); // R10
  AST_PIN_QUIET_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out); // R8
  AST_PULSE_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && pin_oe) |-> pin_out); // R6
endmodule

// File: tb/test_xfer_strobe_gen.sv
module test_xfer_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] interval_n;
  logic        int_mode;
  logic        pin_in;
  logic        pin_out, pin_oe, xfer_stb;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int exp_q[$];
  string tag_q[$];
  int last_stb = -100;
  bit chk_pulse = 1'b0;
  bit chk_small = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xfer_strobe_gen i_xfer_strobe_gen (
    .clk(clk), .rst_n(rst_n), .interval_n(interval_n), .int_mode(int_mode),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .xfer_stb(xfer_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick_to(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic push(input int c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  // monitor: pop expected strobe cycles and compare
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (xfer_stb) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected strobe", cyc, -1);
        end else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(cyc == e, t, cyc, e);
          last_stb = cyc;
        end
      end
      if (chk_pulse && cyc == last_stb + 7) check(pin_out == 1'b1, "R6 pin high last", pin_out, 1);
      if (chk_pulse && cyc == last_stb + 8) check(pin_out == 1'b0, "R6 pin low after", pin_out, 0);
      if (chk_small) check(pin_out == 1'b1, "R7 pin held high", pin_out, 1);
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    automatic int r;
    automatic int c;
    rst_n = 1'b0; int_mode = 1'b0; pin_in = 1'b0; interval_n = 32'd5;
    repeat (3) @(negedge clk);
    check(pin_oe == 1'b1, "R2 oe in reset", pin_oe, 1);
    check(xfer_stb == 1'b0, "R2 strobe in reset", xfer_stb, 0);
    check(pin_out == 1'b0, "R2 pin in reset", pin_out, 0);

    // self-timed, N=5 -> spacing 12
    int_mode = 1'b1;
    r = cyc;
    for (int k = 0; k < 4; k++) push(r + 2 + 12 * k, "R5 spacing N=5");
    rst_n = 1'b1;
    chk_pulse = 1'b1;
    tick_to(r + 47);
    chk_pulse = 1'b0;
    int_mode = 1'b0;
    tick_to(r + 50);
    check(pin_oe == 1'b0, "R8 oe released", pin_oe, 0);
    check(pin_out == 1'b0, "R8 pin low ext", pin_out, 0);

    // pin-driven: short and medium pulses
    for (int i = 0; i < 2; i++) begin
      c = cyc; pin_in = 1'b1; push(c + 3, "R3 ext latency");
      tick_to(c + 4); pin_in = 1'b0; tick_to(c + 9);
    end
    // long high: one strobe only
    c = cyc; pin_in = 1'b1; push(c + 3, "R1 long high one strobe");
    tick_to(c + 25); pin_in = 1'b0; tick_to(c + 30);
    // one-cycle high
    c = cyc; pin_in = 1'b1; push(c + 3, "R1 one-cycle high");
    tick_to(c + 1); pin_in = 1'b0; tick_to(c + 8);

    // self-timed, N=2 -> pin held high, spacing 6; pin activity ignored
    interval_n = 32'd2;
    tick_to(cyc + 2);
    c = cyc; int_mode = 1'b1;
    for (int k = 0; k < 4; k++) push(c + 3 + 6 * k, "R7 spacing N=2");
    tick_to(c + 1);
    check(pin_oe == 1'b1, "R8 oe driven", pin_oe, 1);
    chk_small = 1'b1;
    tick_to(c + 4);  pin_in = 1'b1;
    tick_to(c + 9);  pin_in = 1'b0;
    tick_to(c + 12); pin_in = 1'b1;
    tick_to(c + 13); pin_in = 1'b0;  // R9: no strobes from these
    tick_to(c + 22);
    chk_small = 1'b0;
    int_mode = 1'b0;

    // self-timed, N=7 -> spacing 16, reload continues (R4)
    interval_n = 32'd7;
    tick_to(cyc + 4);
    c = cyc; int_mode = 1'b1; last_stb = -100;
    for (int k = 0; k < 3; k++) push(c + 3 + 16 * k, "R4 reload N=7");
    chk_pulse = 1'b1;
    tick_to(c + 44);
    chk_pulse = 1'b0;
    int_mode = 1'b0;
    tick_to(cyc + 20);
    check(exp_q.size() == 0, "R5 all strobes seen", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule